// File: doc/BRIEF.md
# Move-to-Front Line Buffer

A small fully associative store of tagged data words that keeps its entries in recency order by physically moving them. Slot 0 always holds the most recently used entry. When an entry is used, it is pulled to slot 0, and every entry that sat in front of it moves back one slot. New addresses always enter at slot 0. The occupant of the last slot is the one lost when a new address arrives and the buffer is full.

The block has two ports. The probe port takes an address and answers at once with a hit flag and the stored word. A promote strobe lets a hit on that port also refresh the entry's recency. The write port takes an address and a data word. It either refreshes an entry that is already present or inserts a new one. Any reordering takes effect at the next rising clock edge. Depth and widths are parameters, and the default depth is 4.

Top module: `mtf_line_buffer`

## Requirements
- R1: After reset no entry is valid, so every probe reports `lk_hit`=0 and `lk_data`=0 until a write is made.
- R2: `lk_hit` and `lk_data` are combinational from the current contents, whatever the value of `lk_en`. A probe that matches no valid entry gives `lk_hit`=0 and `lk_data`=0.
- R3: A probe with `lk_en`=1 that hits the entry at slot k moves that entry to slot 0 at the next edge. Slots 0..k-1 each move back one place, and slots above k stay where they are.
- R4: A promoting probe that hits slot 0 leaves the order and contents unchanged.
- R5: A write whose address misses moves every entry back one slot, drops the entry in the last slot, and stores the new address and data at slot 0.
- R6: A write whose address hits moves that entry to the front, as in R3, and replaces its data with the write data.
- R7: When `wr_en`=1 and `lk_addr` equals `wr_addr` in the same cycle, the probe reports `lk_hit`=1 and `lk_data`=`wr_data`.
- R8: When a write and a promoting probe to a different address occur in the same cycle, only the write changes the order. The probe still reports the hit from the current contents.
- R9: A probe with `lk_en`=0, or one that misses, leaves the order and contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_en | input | 1 | Promote the probed entry on a hit |
| lk_addr | input | TAG_W | Probe address |
| lk_hit | output | 1 | Probe address matches a valid entry, or a same-cycle write |
| lk_data | output | DATA_W | Stored word on a hit, zero on a miss |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | TAG_W | Write address |
| wr_data | input | DATA_W | Write data |

## Verification
The assertions rely on every address being present in at most one slot. This holds as long as all writes go through the write port, because a write to a present address refreshes that entry instead of adding a copy. They also assume the inputs are stable around the rising edge. The bench drives every input at the falling edge and never forces the stored state, so both assumptions hold. The slot order cannot be read directly. The stimulus therefore shows it through the order in which later inserts push entries out, probing with `lk_en`=0 so that the observation does not itself reorder the buffer.

// File: rtl/mtf_pkg.sv
package mtf_pkg;
   typedef enum logic [1:0] {
      MTF_HOLD    = 2'd0,
      MTF_PROMOTE = 2'd1,
      MTF_REFRESH = 2'd2,
      MTF_INSERT  = 2'd3
   } mtf_op_e;
endpackage

// File: rtl/mtf_match.sv
module mtf_match #(
   parameter int DEPTH = 4,
   parameter int TAG_W = 16,
   parameter int IDX_W = 2
) (
   input  logic [TAG_W-1:0] key,
   input  logic [DEPTH-1:0] valid,
   input  logic [TAG_W-1:0] tags [DEPTH],
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   logic [DEPTH-1:0] eq;

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
         assign eq[g] = valid[g] && (tags[g] == key);
      end
   endgenerate

   // lowest slot wins if several match
   always_comb begin
      idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (eq[i]) idx = IDX_W'(i);
      end
   end

   assign found = |eq;
endmodule

// File: rtl/mtf_shift.sv
module mtf_shift #(
   parameter int DEPTH  = 4,
   parameter int TAG_W  = 16,
   parameter int DATA_W = 32,
   parameter int IDX_W  = 2
) (
   input  logic [IDX_W-1:0]  sel,
   input  logic [TAG_W-1:0]  front_tag,
   input  logic [DATA_W-1:0] front_data,
   input  logic [DEPTH-1:0]  cur_valid,
   input  logic [TAG_W-1:0]  cur_tag  [DEPTH],
   input  logic [DATA_W-1:0] cur_data [DEPTH],
   output logic [DEPTH-1:0]  nxt_valid,
   output logic [TAG_W-1:0]  nxt_tag  [DEPTH],
   output logic [DATA_W-1:0] nxt_data [DEPTH]
);
   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         if (g == 0) begin : g_head
            assign nxt_valid[g] = 1'b1;
            assign nxt_tag[g]   = front_tag;
            assign nxt_data[g]  = front_data;
         end else begin : g_tail
            logic take_prev;
            assign take_prev    = (IDX_W'(g) <= sel);
            assign nxt_valid[g] = take_prev ? cur_valid[g-1] : cur_valid[g];
            assign nxt_tag[g]   = take_prev ? cur_tag[g-1]   : cur_tag[g];
            assign nxt_data[g]  = take_prev ? cur_data[g-1]  : cur_data[g];
         end
      end
   endgenerate
endmodule

// File: rtl/mtf_line_buffer.sv
module mtf_line_buffer #(
   parameter int DEPTH  = 4,
   parameter int TAG_W  = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_en,
   input  logic [TAG_W-1:0]  lk_addr,
   output logic              lk_hit,
   output logic [DATA_W-1:0] lk_data,
   input  logic              wr_en,
   input  logic [TAG_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0] wr_data
);
   import mtf_pkg::*;

   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("mtf_line_buffer: DEPTH must be at least 2");
      end
      if (TAG_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("mtf_line_buffer: TAG_W and DATA_W must be positive");
      end
   endgenerate

   logic [DEPTH-1:0]  valid_q;
   logic [TAG_W-1:0]  tag_q  [DEPTH];
   logic [DATA_W-1:0] data_q [DEPTH];

   logic              lk_found, wr_found;
   logic [IDX_W-1:0]  lk_idx, wr_idx;

   mtf_match #(.DEPTH(DEPTH), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_lk_match (
      .key(lk_addr), .valid(valid_q), .tags(tag_q),
      .found(lk_found), .idx(lk_idx)
   );

   mtf_match #(.DEPTH(DEPTH), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_wr_match (
      .key(wr_addr), .valid(valid_q), .tags(tag_q),
      .found(wr_found), .idx(wr_idx)
   );

   // probe result, with same-cycle write bypass
   logic bypass;
   assign bypass = wr_en && (wr_addr == lk_addr);

   always_comb begin
      if (bypass) begin
         lk_hit  = 1'b1;
         lk_data = wr_data;
      end else if (lk_found) begin
         lk_hit  = 1'b1;
         lk_data = data_q[lk_idx];
      end else begin
         lk_hit  = 1'b0;
         lk_data = '0;
      end
   end

   // operation select: write beats promote
   mtf_op_e           op;
   logic [IDX_W-1:0]  sel;
   logic [TAG_W-1:0]  front_tag;
   logic [DATA_W-1:0] front_data;

   always_comb begin
      if (wr_en) op = wr_found ? MTF_REFRESH : MTF_INSERT;
      else if (lk_en && lk_found) op = MTF_PROMOTE;
      else op = MTF_HOLD;
   end

   always_comb begin
      unique case (op)
         MTF_INSERT: begin
            sel        = IDX_W'(DEPTH - 1);
            front_tag  = wr_addr;
            front_data = wr_data;
         end
         MTF_REFRESH: begin
            sel        = wr_idx;
            front_tag  = wr_addr;
            front_data = wr_data;
         end
         default: begin
            sel        = lk_idx;
            front_tag  = tag_q[lk_idx];
            front_data = data_q[lk_idx];
         end
      endcase
   end

   logic [DEPTH-1:0]  nxt_valid;
   logic [TAG_W-1:0]  nxt_tag  [DEPTH];
   logic [DATA_W-1:0] nxt_data [DEPTH];

   mtf_shift #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_shift (
      .sel(sel), .front_tag(front_tag), .front_data(front_data),
      .cur_valid(valid_q), .cur_tag(tag_q), .cur_data(data_q),
      .nxt_valid(nxt_valid), .nxt_tag(nxt_tag), .nxt_data(nxt_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            tag_q[i]  <= '0;
            data_q[i] <= '0;
         end
      end else if (op != MTF_HOLD) begin
         valid_q <= nxt_valid;
         for (int i = 0; i < DEPTH; i++) begin
            tag_q[i]  <= nxt_tag[i];
            data_q[i] <= nxt_data[i];
         end
      end
   end
endmodule

// File: rtl/mtf_line_buffer_chk.sv
module mtf_line_buffer_chk #(
   parameter int DEPTH  = 4,
   parameter int TAG_W  = 16,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lk_en,
   input logic [TAG_W-1:0]  lk_addr,
   input logic              lk_hit,
   input logic [DATA_W-1:0] lk_data,
   input logic              wr_en,
   input logic [TAG_W-1:0]  wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [DEPTH-1:0]  valid_vec,
   input logic [TAG_W-1:0]  head_tag,
   input logic [DATA_W-1:0] head_data
);
   // R5 R6
   write_to_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> valid_vec[0] && head_tag == $past(wr_addr) && head_data == $past(wr_data));

   // R3
   promote_to_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_en && lk_hit && !wr_en) |=> head_tag == $past(lk_addr) && head_data == $past(lk_data));

   // R7
   bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && lk_addr == wr_addr) |-> (lk_hit && lk_data == wr_data));

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !(lk_en && lk_hit)) |=> $stable(valid_vec) && $stable(head_tag) && $stable(head_data));

   // R2
   empty_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_vec == '0 && !wr_en) |-> (!lk_hit && lk_data == '0));

   // R5
   fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $countones(valid_vec) <= $past($countones(valid_vec)) + 1);
endmodule

bind mtf_line_buffer mtf_line_buffer_chk #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_addr(lk_addr),
   .lk_hit(lk_hit), .lk_data(lk_data), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .valid_vec(valid_q), .head_tag(tag_q[0]), .head_data(data_q[0])
);

// File: tb/test_mtf_line_buffer.sv
`timescale 1ns/1ps
module test_mtf_line_buffer;
   localparam int DEPTH  = 4;
   localparam int TAG_W  = 8;
   localparam int DATA_W = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              lk_en = 1'b0;
   logic [TAG_W-1:0]  lk_addr = '0;
   logic              lk_hit;
   logic [DATA_W-1:0] lk_data;
   logic              wr_en = 1'b0;
   logic [TAG_W-1:0]  wr_addr = '0;
   logic [DATA_W-1:0] wr_data = '0;

   int errs = 0;
   int nchk = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   mtf_line_buffer #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_mtf_line_buffer (
      .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_addr(lk_addr),
      .lk_hit(lk_hit), .lk_data(lk_data), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data)
   );

   typedef struct packed {
      logic              we;
      logic [TAG_W-1:0]  wa;
      logic [DATA_W-1:0] wd;
      logic              le;
      logic [TAG_W-1:0]  la;
      logic              eh;
      logic [DATA_W-1:0] ed;
   } vec_t;

   // contents before the edge are noted per row, slot 0 first
   localparam int NVEC = 17;
   localparam vec_t VECS [NVEC] = '{
      '{1'b1, 8'h10, 16'h1111, 1'b0, 8'h10, 1'b1, 16'h1111}, // [] bypass R7
      '{1'b1, 8'h20, 16'h2222, 1'b0, 8'h10, 1'b1, 16'h1111}, // [10] R2
      '{1'b1, 8'h30, 16'h3333, 1'b0, 8'h99, 1'b0, 16'h0000}, // [20,10] miss R2
      '{1'b1, 8'h40, 16'h4444, 1'b0, 8'h20, 1'b1, 16'h2222}, // [30,20,10] R9
      '{1'b0, 8'h00, 16'h0000, 1'b1, 8'h10, 1'b1, 16'h1111}, // [40,30,20,10] promote R3
      '{1'b1, 8'h50, 16'h5555, 1'b0, 8'h20, 1'b1, 16'h2222}, // [10,40,30,20] R5
      '{1'b0, 8'h00, 16'h0000, 1'b0, 8'h20, 1'b0, 16'h0000}, // [50,10,40,30] dropped R5
      '{1'b1, 8'h40, 16'h4AAA, 1'b1, 8'h40, 1'b1, 16'h4AAA}, // write hit + bypass R6 R7
      '{1'b0, 8'h00, 16'h0000, 1'b1, 8'h40, 1'b1, 16'h4AAA}, // [40,50,10,30] R6 R4
      '{1'b1, 8'h60, 16'h6666, 1'b0, 8'h30, 1'b1, 16'h3333}, // 30 last R6
      '{1'b0, 8'h00, 16'h0000, 1'b0, 8'h30, 1'b0, 16'h0000}, // [60,40,50,10] R5
      '{1'b1, 8'h70, 16'h7777, 1'b1, 8'h10, 1'b1, 16'h1111}, // write wins R8
      '{1'b0, 8'h00, 16'h0000, 1'b0, 8'h10, 1'b0, 16'h0000}, // [70,60,40,50] R8
      '{1'b0, 8'h00, 16'h0000, 1'b1, 8'h99, 1'b0, 16'h0000}, // miss promote R9
      '{1'b1, 8'h80, 16'h8888, 1'b0, 8'h50, 1'b1, 16'h5555}, // R9
      '{1'b0, 8'h00, 16'h0000, 1'b0, 8'h50, 1'b0, 16'h0000}, // [80,70,60,40] R9
      '{1'b0, 8'h00, 16'h0000, 1'b0, 8'h40, 1'b1, 16'h4AAA}  // R6
   };

   task automatic check(input string req, input logic eh, input logic [DATA_W-1:0] ed);
      nchk++;
      if (lk_hit !== eh || lk_data !== ed) begin
         errs++;
         $display("FAIL %s addr=%h actual hit=%b data=%h expected hit=%b data=%h",
                  req, lk_addr, lk_hit, lk_data, eh, ed);
      end
   endtask

   // inputs set just after a falling edge, outputs sampled 1 ns later, then one clock
   task automatic cycle(input logic we, input logic [TAG_W-1:0] wa, input logic [DATA_W-1:0] wd,
                        input logic le, input logic [TAG_W-1:0] la,
                        input string req, input logic eh, input logic [DATA_W-1:0] ed);
      wr_en = we; wr_addr = wa; wr_data = wd; lk_en = le; lk_addr = la;
      #1;
      check(req, eh, ed);
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; lk_en = 1'b0;
   endtask

   task automatic probe(input logic [TAG_W-1:0] la, input string req,
                        input logic eh, input logic [DATA_W-1:0] ed);
      cycle(1'b0, '0, '0, 1'b0, la, req, eh, ed);
   endtask

   task automatic put(input logic [TAG_W-1:0] a);
      cycle(1'b1, a, {a, a}, 1'b0, a, "R7", 1'b1, {a, a});
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      probe(8'h00, "R1", 1'b0, '0);
      probe(8'h10, "R1", 1'b0, '0);

      for (int v = 0; v < NVEC; v++) begin
         cycle(VECS[v].we, VECS[v].wa, VECS[v].wd, VECS[v].le, VECS[v].la,
               "R2-R9 table", VECS[v].eh, VECS[v].ed);
      end

      // reset in mid-run clears everything
      do_reset();
      probe(8'h80, "R1", 1'b0, '0);
      probe(8'h40, "R1", 1'b0, '0);

      // R3: promote from slot 2, then eviction order
      put(8'hA1); put(8'hB2); put(8'hC3); put(8'hD4);     // [D4,C3,B2,A1]
      cycle(1'b0, '0, '0, 1'b1, 8'hB2, "R3", 1'b1, 16'hB2B2); // [B2,D4,C3,A1]
      put(8'hE5);                                        // [E5,B2,D4,C3]
      put(8'hF6);                                        // [F6,E5,B2,D4]
      probe(8'hA1, "R3", 1'b0, '0);
      probe(8'hC3, "R3", 1'b0, '0);
      probe(8'hD4, "R3", 1'b1, 16'hD4D4);
      probe(8'hB2, "R3", 1'b1, 16'hB2B2);

      // R4: promote slot 0 repeatedly, order kept
      cycle(1'b0, '0, '0, 1'b1, 8'hF6, "R4", 1'b1, 16'hF6F6);
      cycle(1'b0, '0, '0, 1'b1, 8'hF6, "R4", 1'b1, 16'hF6F6);
      put(8'h11);                                        // [11,F6,E5,B2]
      probe(8'hD4, "R4", 1'b0, '0);
      probe(8'hB2, "R4", 1'b1, 16'hB2B2);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, nchk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errs++;
         nchk++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, nchk);
         $finish;
      end
   end
endmodule